// File: doc/BRIEF.md
# DLL Phase Offset Adder

This block trims the delay setting that a delay-locked loop produces for the read strobe delay chain. The loop's counter delivers an unsigned 6-bit setting. The block shifts that setting by a signed phase offset and clamps the sum to the range the delay buffers accept. The registered result then steers the strobe delay, so a designer can move the capture point a few taps either side of the loop's nominal centre.

There are two independent offset channels, A and B, and each has its own configuration. A channel in static mode adds a fixed signed parameter between -63 and +63. A channel in dynamic mode takes a 6-bit unsigned magnitude from an input bus, and a per-channel subtract control decides whether that magnitude is added or subtracted.

The frequency-mode parameter sets the upper clamp: 63 in the low-frequency mode and 31 in the high-frequency mode. Each output register loads only when the loop's update-enable strobe is high and otherwise holds its value.

Top module: `dll_phase_offset_adder`

## Requirements
- R1: While `rst_n` is low, both `adj_a` and `adj_b` are 0, whatever the other inputs are.
- R2: A static channel produces `dll_set + STATIC_OFS`, where `STATIC_OFS` is the channel's signed parameter (default +10 for A), clamped as in R5 to R7.
- R3: A dynamic channel with its subtract control at 0 produces `dll_set + offset`. The offset bus is an unsigned 6-bit magnitude, 0 to 63.
- R4: A dynamic channel with its subtract control at 1 produces `dll_set - offset`.
- R5: A sum below 0 gives an output of 0.
- R6: In the low-frequency mode (`HIGH_FREQ` = 0), a sum above 63 gives an output of 63.
- R7: In the high-frequency mode (`HIGH_FREQ` = 1), a sum above 31 gives 31, and no output is ever above 31.
- R8: An output takes the value computed from the inputs sampled at a rising clock edge where `upd_en` is 1. The new value is visible after that edge and not before it: one cycle of latency.
- R9: While `upd_en` is 0, both outputs hold their values, even when the setting, offsets or subtract controls change.
- R10: Channel A's offset and subtract inputs have no effect on `adj_b`, and channel B's have no effect on `adj_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dll_set | input | 6 | Unsigned delay setting from the loop counter |
| upd_en | input | 1 | Update strobe; the output registers load while it is high |
| ofs_a | input | 6 | Offset magnitude for channel A (dynamic mode only) |
| sub_a | input | 1 | Channel A: 1 subtracts the offset, 0 adds it |
| ofs_b | input | 6 | Offset magnitude for channel B (dynamic mode only) |
| sub_b | input | 1 | Channel B: 1 subtracts the offset, 0 adds it |
| adj_a | output | 6 | Adjusted, clamped setting from channel A |
| adj_b | output | 6 | Adjusted, clamped setting from channel B |

## Verification
The only state is the two output registers, so a wrong internal value shows on `adj_a` or `adj_b` one edge after an update strobe. Because the register holds while `upd_en` is low, the error then persists until the next strobe.

A wrong sign or extension in the offset path shows up mainly near the ends of the range. For this reason the vectors push sums below zero and past both ceilings. A leaking update gate shows up as an output that moves during a stretch with the strobe low.

// File: rtl/pofs_pkg.sv
package pofs_pkg;
  localparam int SET_W = 6;
  localparam int ACC_W = SET_W + 2;

  // Upper clamp bound for the selected frequency mode
  function automatic logic [SET_W-1:0] mode_ceiling(input bit high_freq);
    logic [SET_W-1:0] c;
    if (high_freq) c = SET_W'((1 << (SET_W - 1)) - 1);
    else           c = SET_W'((1 << SET_W) - 1);
    return c;
  endfunction

  // Signed offset applied to the loop setting
  function automatic logic signed [ACC_W-1:0] pick_offset(
    input bit                 dynamic_mode,
    input int                 static_ofs,
    input logic [SET_W-1:0]   magnitude,
    input logic               subtract
  );
    logic signed [ACC_W-1:0] mag_s;
    mag_s = $signed({2'b00, magnitude});
    if (dynamic_mode) return subtract ? -mag_s : mag_s;
    else              return ACC_W'(static_ofs);
  endfunction

  // Widen the setting and add the offset
  function automatic logic signed [ACC_W-1:0] widen_add(
    input logic [SET_W-1:0]        setting,
    input logic signed [ACC_W-1:0] ofs
  );
    return $signed({2'b00, setting}) + ofs;
  endfunction

  // Clamp a signed sum into 0..ceiling
  function automatic logic [SET_W-1:0] saturate(
    input logic signed [ACC_W-1:0] v,
    input logic [SET_W-1:0]        ceiling
  );
    logic [SET_W-1:0] r;
    if (v < 0)                                     r = '0;
    else if (v > $signed({2'b00, ceiling}))        r = ceiling;
    else                                           r = v[SET_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pofs_source.sv
module pofs_source
  import pofs_pkg::*;
#(
  parameter bit DYNAMIC    = 1'b0,
  parameter int STATIC_OFS = 0
) (
  input  logic [SET_W-1:0]        mag,
  input  logic                    sub,
  output logic signed [ACC_W-1:0] ofs
);
  always_comb ofs = pick_offset(DYNAMIC, STATIC_OFS, mag, sub);

  initial begin
    AST_STATIC_RANGE: assert (STATIC_OFS >= -63 && STATIC_OFS <= 63); // R2
  end
endmodule

// File: rtl/pofs_sat.sv
module pofs_sat
  import pofs_pkg::*;
#(
  parameter bit HIGH_FREQ = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SET_W-1:0]        setting,
  input  logic signed [ACC_W-1:0] ofs,
  output logic [SET_W-1:0]        clamped
);
  localparam logic [SET_W-1:0] CEIL = mode_ceiling(HIGH_FREQ);

  logic signed [ACC_W-1:0] raw_sum;
  logic                    under_zero;
  logic                    over_ceil;

  always_comb begin
    raw_sum    = widen_add(setting, ofs);
    under_zero = raw_sum < 0;
    over_ceil  = raw_sum > $signed({2'b00, CEIL});
    clamped    = saturate(raw_sum, CEIL);
  end

  AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    under_zero |-> clamped == '0); // R5
  AST_CEIL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    over_ceil |-> clamped == CEIL); // R6
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!under_zero && !over_ceil) |-> clamped == raw_sum[SET_W-1:0]); // R3
endmodule

// File: rtl/pofs_hold.sv
module pofs_hold
  import pofs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] d,
  output logic [SET_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R9
endmodule

// File: rtl/dll_phase_offset_adder.sv
module dll_phase_offset_adder
  import pofs_pkg::*;
#(
  parameter bit HIGH_FREQ    = 1'b0,
  parameter bit A_DYNAMIC    = 1'b0,
  parameter int A_STATIC_OFS = 10,
  parameter bit B_DYNAMIC    = 1'b1,
  parameter int B_STATIC_OFS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       dll_set,
  input  logic             upd_en,
  input  logic [5:0]       ofs_a,
  input  logic             sub_a,
  input  logic [5:0]       ofs_b,
  input  logic             sub_b,
  output logic [5:0]       adj_a,
  output logic [5:0]       adj_b
);
  localparam int NCH = 2;
  localparam logic [SET_W-1:0] CEIL = mode_ceiling(HIGH_FREQ);

  logic [SET_W-1:0] ch_mag [NCH];
  logic             ch_sub [NCH];
  logic [SET_W-1:0] ch_out [NCH];

  always_comb begin
    ch_mag[0] = ofs_a;
    ch_mag[1] = ofs_b;
    ch_sub[0] = sub_a;
    ch_sub[1] = sub_b;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit DYN = (g == 0) ? A_DYNAMIC : B_DYNAMIC;
    localparam int SOF = (g == 0) ? A_STATIC_OFS : B_STATIC_OFS;

    logic signed [ACC_W-1:0] ofs_w;
    logic [SET_W-1:0]        next_w;

    pofs_source #(.DYNAMIC(DYN), .STATIC_OFS(SOF)) src_i (
      .mag (ch_mag[g]),
      .sub (ch_sub[g]),
      .ofs (ofs_w)
    );

    pofs_sat #(.HIGH_FREQ(HIGH_FREQ)) sat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .setting (dll_set),
      .ofs     (ofs_w),
      .clamped (next_w)
    );

    pofs_hold hold_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (upd_en),
      .d     (next_w),
      .q     (ch_out[g])
    );
  end

  assign adj_a = ch_out[0];
  assign adj_b = ch_out[1];

  AST_OUT_CEIL_A: assert property (@(posedge clk) disable iff (!rst_n)
    adj_a <= CEIL); // R7
  AST_OUT_CEIL_B: assert property (@(posedge clk) disable iff (!rst_n)
    adj_b <= CEIL); // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (adj_a == '0 && adj_b == '0)); // R1
endmodule

// File: tb/dll_phase_offset_adder_tb_top.sv
module dll_phase_offset_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {set[24:19], ofs_b[18:13], sub_b[12], exp_a[11:6], exp_b[5:0]}
  // dut_i: low-frequency mode, A static +10, B dynamic
  localparam logic [24:0] VEC [NVEC] = '{
    {6'd20, 6'd5,  1'b0, 6'd30, 6'd25},
    {6'd20, 6'd5,  1'b1, 6'd30, 6'd15},
    {6'd3,  6'd10, 1'b1, 6'd13, 6'd0 },
    {6'd60, 6'd10, 1'b0, 6'd63, 6'd63},
    {6'd0,  6'd63, 1'b0, 6'd10, 6'd63},
    {6'd63, 6'd63, 1'b1, 6'd63, 6'd0 },
    {6'd40, 6'd0,  1'b0, 6'd50, 6'd40},
    {6'd53, 6'd0,  1'b1, 6'd63, 6'd53}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] dll_set = '0;
  logic upd_en = 1'b0;
  logic [5:0] ofs_a = '0;
  logic sub_a = 1'b0;
  logic [5:0] ofs_b = '0;
  logic sub_b = 1'b0;
  logic [5:0] adj_a, adj_b, hf_a, hf_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_phase_offset_adder dut_i (
    .clk(clk), .rst_n(rst_n), .dll_set(dll_set), .upd_en(upd_en),
    .ofs_a(ofs_a), .sub_a(sub_a), .ofs_b(ofs_b), .sub_b(sub_b),
    .adj_a(adj_a), .adj_b(adj_b)
  );

  dll_phase_offset_adder #(
    .HIGH_FREQ(1'b1), .A_DYNAMIC(1'b0), .A_STATIC_OFS(-20),
    .B_DYNAMIC(1'b1), .B_STATIC_OFS(0)
  ) hf_i (
    .clk(clk), .rst_n(rst_n), .dll_set(dll_set), .upd_en(upd_en),
    .ofs_a(ofs_a), .sub_a(sub_a), .ofs_b(ofs_b), .sub_b(sub_b),
    .adj_a(hf_a), .adj_b(hf_b)
  );

  function automatic int clip(input int v, input int top);
    if (v < 0) return 0;
    if (v > top) return top;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at the falling edge, capture on the next rising edge, sample after it
  task automatic apply(input int s, input int oa, input bit sa,
                       input int ob, input bit sb, input bit u);
    @(negedge clk);
    dll_set = 6'(s); ofs_a = 6'(oa); sub_a = sa;
    ofs_b = 6'(ob); sub_b = sb; upd_en = u;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state with the update strobe high
    upd_en = 1'b1; dll_set = 6'd30; ofs_b = 6'd7;
    repeat (3) @(negedge clk);
    check("R1 adj_a", adj_a, 0);
    check("R1 adj_b", adj_b, 0);
    check("R1 hf_a", hf_a, 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][24:19], 0, 1'b0, VEC[i][18:13], VEC[i][12], 1'b1);
      check("R2/R6 static A vector", adj_a, VEC[i][11:6]);
      check("R3/R4/R5 dynamic B vector", adj_b, VEC[i][5:0]);
    end

    // R7: high-frequency mode, A static -20, B dynamic
    apply(50, 0, 1'b0, 10, 1'b0, 1'b1);
    check("R7 hf_a", hf_a, clip(50 - 20, 31));
    check("R7 hf_b", hf_b, clip(50 + 10, 31));
    apply(10, 0, 1'b0, 5, 1'b1, 1'b1);
    check("R5 hf_a", hf_a, clip(10 - 20, 31));
    check("R7 hf_b", hf_b, clip(10 - 5, 31));
    apply(25, 0, 1'b0, 10, 1'b0, 1'b1);
    check("R7 hf_b 35", hf_b, 31);
    apply(40, 0, 1'b0, 5, 1'b1, 1'b1);
    check("R7 hf_b 35 sub", hf_b, 31);

    // R8: latency of one edge
    apply(10, 0, 1'b0, 2, 1'b0, 1'b1);
    @(negedge clk);
    dll_set = 6'd30; ofs_b = 6'd4; sub_b = 1'b0;
    #1;
    check("R8 before edge", adj_b, 12);
    @(posedge clk); #1;
    check("R8 after edge", adj_b, 34);
    check("R8 after edge A", adj_a, 40);

    // R9: hold with the strobe low
    @(negedge clk);
    upd_en = 1'b0; dll_set = 6'd1; ofs_b = 6'd50; sub_b = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 hold A", adj_a, 40);
    check("R9 hold B", adj_b, 34);
    check("R9 hold hf_b", hf_b, 31);

    // R10: channel isolation
    apply(20, 0, 1'b0, 3, 1'b0, 1'b1);
    check("R10 base A", adj_a, 30);
    check("R10 base B", adj_b, 23);
    apply(20, 63, 1'b1, 3, 1'b0, 1'b1);
    check("R10 A inputs vs B", adj_b, 23);
    apply(20, 63, 1'b1, 9, 1'b1, 1'b1);
    check("R10 B inputs vs A", adj_a, 30);
    check("R10 B moved", adj_b, 11);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule